// File: doc/BRIEF.md
# Two-Phase Shared-Medium Access Sequencer

This block runs the channel access schedule for one hub on a shared on-chip wireless medium. Time alternates between two phases. In the data phase a single token circulates around a virtual ring of hubs. Only the current holder may send, point-to-point. In the control phase every hub broadcasts a short congestion word at the same moment, and the hubs are separated by orthogonal codes. The block tracks the token holder, ends each data phase on a cycle budget or a flit budget, and drives the phase flag `done`. It also forms this hub's 3-bit congestion word from local virtual-channel occupancy.

When a control phase closes, the block captures the words received from every hub into a global availability map, all in one clock edge. Routing logic reads this map during the next data phase. The crossbar hold output stays high for the whole control phase, so no switch traversal starts while the map is being refreshed.

The sequencer has two named states. The names match the RTL enumerators. `PH_DATA` moves to `PH_CTRL` when the cycle budget is used up or the flit budget is reached; at that same edge the token moves on. `PH_CTRL` moves to `PH_DATA` after `CTRL_CYC` cycles; at that same edge the map loads.

Top module: `wmac_seq`

## Requirements
- R1: After reset the block is in the data phase. In this state the token sits at hub 0, `done` and `xbar_hold` are low, and every map entry reads 3'b100 (full, channel 0). `tx_grant` is high only if `HUB_ID` is 0.
- R2: When no flits are sent, a data phase lasts exactly `EPOCH_CYC` cycles before `done` rises.
- R3: A data phase ends after the `FLIT_LIMIT`-th flit cycle (`flit_tx` high) if that comes before the cycle budget. The end condition is the OR of the two limits.
- R4: `done` stays high for exactly `CTRL_CYC` cycles per control phase, then falls.
- R5: The token advances by one hub at each data-to-control transition and wraps from `N_HUBS-1` to 0.
- R6: `tx_grant` is high only in the data phase and only while the token equals `HUB_ID`.
- R7: `xbar_hold` is high exactly while `done` is high.
- R8: `ctrl_word[2]` is 1 when every virtual channel is busy. `ctrl_word[1:0]` is the lowest-numbered free channel, or 0 when none is free.
- R9: `avail_map` changes only at the edge where `done` falls, and the whole map loads at that edge. Entry i occupies bits [3i+2:3i]. It is taken from `rx_words[3i+2:3i]`, except that entry `HUB_ID` is taken from this hub's own `ctrl_word`.
- R10: `flit_tx` during a control phase does not count toward the next data phase's flit budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vc_busy | input | NUM_VC | Local virtual-channel occupancy, 1 = holds a packet |
| flit_tx | input | 1 | A data flit occupied the medium this cycle |
| rx_words | input | N_HUBS*3 | Demodulated control words, one 3-bit slice per hub |
| done | output | 1 | Phase flag: 1 = control phase |
| token_hub | output | $clog2(N_HUBS) | Current token holder |
| tx_grant | output | 1 | This hub may transmit data |
| xbar_hold | output | 1 | Blocks crossbar output access |
| ctrl_word | output | 3 | This hub's congestion word |
| avail_map | output | N_HUBS*3 | Latched global availability map |

## Verification
Data phases are run with three flit patterns. With no flits, the cycle budget alone ends the phase. With a flit every cycle, the flit budget alone ends it. With a flit every other cycle, the two budgets give different lengths, so an AND of the limits or an off-by-one in either counter shows up. Flits are injected through every control phase, and the following idle data phase must still last the full budget. Phases are repeated past the ring size to observe the token wrap and the single cycle in which this hub holds the grant. Two different received-word patterns are captured, so that a map which updates early or partially shows up. The priority encoder is swept over all sixteen occupancy values.

// File: rtl/wmac_pkg.sv
package wmac_pkg;
    typedef enum logic {
        PH_DATA = 1'b0,
        PH_CTRL = 1'b1
    } phase_e;
endpackage

// File: rtl/wmac_vc_enc.sv
module wmac_vc_enc #(
    parameter int NUM_VC = 4,
    localparam int VCW   = $clog2(NUM_VC)
) (
    input  logic [NUM_VC-1:0] vc_busy,
    output logic [VCW:0]      word
);
    logic [VCW-1:0] low_free;

    always_comb begin
        low_free = '0;
        for (int i = NUM_VC - 1; i >= 0; i--) begin
            if (!vc_busy[i]) low_free = VCW'(i);
        end
        word = {&vc_busy, low_free};
    end

    always_comb begin
        if (!word[VCW]) begin
            AST_FREE_IS_FREE: assert (!vc_busy[word[VCW-1:0]]); // R8
        end
    end
endmodule

// File: rtl/wmac_phase_fsm.sv
module wmac_phase_fsm
    import wmac_pkg::*;
#(
    parameter int N_HUBS     = 4,
    parameter int EPOCH_CYC  = 6,
    parameter int FLIT_LIMIT = 3,
    parameter int CTRL_CYC   = 3,
    localparam int IDW = $clog2(N_HUBS),
    localparam int CW  = $clog2(EPOCH_CYC + 1),
    localparam int FW  = $clog2(FLIT_LIMIT + 1),
    localparam int KW  = $clog2(CTRL_CYC + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           flit_tx,
    output logic           done,
    output logic [IDW-1:0] token,
    output logic           load_map
);
    phase_e         st_q, st_d;
    logic [CW-1:0]  cyc_q, cyc_d;
    logic [FW-1:0]  flt_q, flt_d;
    logic [KW-1:0]  ctl_q, ctl_d;
    logic [IDW-1:0] tok_q, tok_d;
    logic           end_data, end_ctrl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PH_DATA;
            cyc_q <= '0;
            flt_q <= '0;
            ctl_q <= '0;
            tok_q <= '0;
        end else begin
            st_q  <= st_d;
            cyc_q <= cyc_d;
            flt_q <= flt_d;
            ctl_q <= ctl_d;
            tok_q <= tok_d;
        end
    end

    always_comb begin
        st_d     = st_q;
        cyc_d    = cyc_q;
        flt_d    = flt_q;
        ctl_d    = ctl_q;
        tok_d    = tok_q;
        end_data = 1'b0;
        end_ctrl = 1'b0;
        unique case (st_q)
            PH_DATA: begin
                end_data = (cyc_q == CW'(EPOCH_CYC - 1)) ||
                           (flit_tx && (flt_q == FW'(FLIT_LIMIT - 1)));
                if (end_data) begin
                    st_d  = PH_CTRL;
                    cyc_d = '0;
                    flt_d = '0;
                    ctl_d = '0;
                    tok_d = (tok_q == IDW'(N_HUBS - 1)) ? '0 : tok_q + 1'b1;
                end else begin
                    cyc_d = cyc_q + 1'b1;
                    if (flit_tx) flt_d = flt_q + 1'b1;
                end
            end
            PH_CTRL: begin
                end_ctrl = (ctl_q == KW'(CTRL_CYC - 1));
                if (end_ctrl) begin
                    st_d  = PH_DATA;
                    ctl_d = '0;
                end else begin
                    ctl_d = ctl_q + 1'b1;
                end
            end
            default: st_d = PH_DATA;
        endcase
    end

    always_comb begin
        done     = (st_q == PH_CTRL);
        token    = tok_q;
        load_map = end_ctrl;
    end

    AST_TOKEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (tok_q == (($past(tok_q) == IDW'(N_HUBS - 1)) ? '0 : $past(tok_q) + 1'b1))); // R5
    AST_TOKEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> $stable(tok_q)); // R5
    AST_EPOCH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (cyc_q < CW'(EPOCH_CYC))); // R2
    AST_CTRL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ctl_q < KW'(CTRL_CYC))); // R4
    AST_FLIT_IDLE_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flt_q == '0)); // R10
endmodule

// File: rtl/wmac_avail_map.sv
module wmac_avail_map #(
    parameter int N_HUBS = 4,
    parameter int HUB_ID = 1,
    parameter int WW     = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                done,
    input  logic [WW-1:0]       own_word,
    input  logic [N_HUBS*WW-1:0] rx_words,
    output logic [N_HUBS*WW-1:0] map
);
    localparam logic [WW-1:0] FULL_WORD = {1'b1, {(WW-1){1'b0}}};

    for (genvar g = 0; g < N_HUBS; g++) begin : g_ent
        logic [WW-1:0] ent_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    ent_q <= FULL_WORD;
            else if (load) ent_q <= (g == HUB_ID) ? own_word : rx_words[g*WW +: WW];
        end
        assign map[g*WW +: WW] = ent_q;
    end

    AST_MAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> $stable(map)); // R9
    AST_MAP_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !$fell(done)) |-> $stable(map)); // R9
endmodule

// File: rtl/wmac_seq.sv
module wmac_seq
    import wmac_pkg::*;
#(
    parameter int N_HUBS     = 4,
    parameter int NUM_VC     = 4,
    parameter int EPOCH_CYC  = 6,
    parameter int FLIT_LIMIT = 3,
    parameter int CTRL_CYC   = 3,
    parameter int HUB_ID     = 1,
    localparam int IDW = $clog2(N_HUBS),
    localparam int WW  = $clog2(NUM_VC) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_VC-1:0]     vc_busy,
    input  logic                  flit_tx,
    input  logic [N_HUBS*WW-1:0]  rx_words,
    output logic                  done,
    output logic [IDW-1:0]        token_hub,
    output logic                  tx_grant,
    output logic                  xbar_hold,
    output logic [WW-1:0]         ctrl_word,
    output logic [N_HUBS*WW-1:0]  avail_map
);
    logic load_map;

    wmac_phase_fsm #(
        .N_HUBS(N_HUBS), .EPOCH_CYC(EPOCH_CYC),
        .FLIT_LIMIT(FLIT_LIMIT), .CTRL_CYC(CTRL_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .flit_tx(flit_tx),
        .done(done), .token(token_hub), .load_map(load_map)
    );

    wmac_vc_enc #(.NUM_VC(NUM_VC)) u_enc (
        .vc_busy(vc_busy), .word(ctrl_word)
    );

    wmac_avail_map #(.N_HUBS(N_HUBS), .HUB_ID(HUB_ID), .WW(WW)) u_map (
        .clk(clk), .rst_n(rst_n), .load(load_map), .done(done),
        .own_word(ctrl_word), .rx_words(rx_words), .map(avail_map)
    );

    always_comb begin
        tx_grant  = !done && (token_hub == IDW'(HUB_ID));
        xbar_hold = done;
    end

    AST_GRANT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_grant |-> !xbar_hold); // R6
    AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xbar_hold) |-> $past(load_map)); // R7
endmodule

// File: tb/sim_wmac_seq.sv
module sim_wmac_seq;
    localparam int N  = 4;
    localparam int E  = 6;
    localparam int F  = 3;
    localparam int C  = 3;
    localparam int HB = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  vc_busy = '0;
    logic        flit_tx = 1'b0;
    logic [11:0] rx_words = '0;
    logic        done, tx_grant, xbar_hold;
    logic [1:0]  token_hub;
    logic [2:0]  ctrl_word;
    logic [11:0] avail_map;

    int checks = 0;
    int errors = 0;
    int exp_tok = 0;
    logic [11:0] exp_map = 12'h924;

    always #5 clk = ~clk;

    wmac_seq #(.N_HUBS(N), .NUM_VC(4), .EPOCH_CYC(E), .FLIT_LIMIT(F),
               .CTRL_CYC(C), .HUB_ID(HB)) u0 (
        .clk(clk), .rst_n(rst_n), .vc_busy(vc_busy), .flit_tx(flit_tx),
        .rx_words(rx_words), .done(done), .token_hub(token_hub),
        .tx_grant(tx_grant), .xbar_hold(xbar_hold), .ctrl_word(ctrl_word),
        .avail_map(avail_map)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] word_of(input logic [3:0] b);
        int lf = 0;
        for (int i = 3; i >= 0; i--) if (!b[i]) lf = i;
        return {(b == 4'hF), 2'(lf)};
    endfunction

    function automatic logic [11:0] map_of(input logic [11:0] rx, input logic [2:0] own);
        logic [11:0] m = rx;
        m[HB*3 +: 3] = own;
        return m;
    endfunction

    // mode 0: no flits, 1: every cycle, 2: every other cycle
    task automatic one_round(input int mode, input int exp_len, input string rq);
        int n = 0;
        chk("R6 grant at data start", tx_grant, (exp_tok == HB));
        chk("R7 hold low in data", xbar_hold, 0);
        while (!done && n < 100) begin
            flit_tx = (mode == 1) || (mode == 2 && (n % 2 == 0));
            n++;
            @(negedge clk);
        end
        flit_tx = 1'b0;
        chk(rq, n, exp_len);
        exp_tok = (exp_tok + 1) % N;
        chk("R5 token after data phase", token_hub, exp_tok);
        chk("R7 hold high in ctrl", xbar_hold, 1);
        chk("R9 map frozen at ctrl start", avail_map, exp_map);
        n = 0;
        while (done && n < 100) begin
            flit_tx = 1'b1;  // R10 stimulus: ignored
            n++;
            @(negedge clk);
            if (done) chk("R9 map frozen in ctrl", avail_map, exp_map);
        end
        flit_tx = 1'b0;
        chk("R4 ctrl length", n, C);
        exp_map = map_of(rx_words, word_of(vc_busy));
        chk("R9 map after falling done", avail_map, exp_map);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 done", done, 0);
        chk("R1 token", token_hub, 0);
        chk("R1 map", avail_map, 12'h924);
        chk("R1 hold", xbar_hold, 0);
        chk("R1 grant", tx_grant, 0);
        vc_busy  = 4'b0011;
        rx_words = 12'hA5C;
        one_round(0, E, "R2 epoch length, no flits");
        one_round(0, E, "R10 ctrl flits not counted");
        one_round(1, F, "R3 flit limit, every cycle");
        vc_busy  = 4'b1111;
        rx_words = 12'h3B6;
        one_round(2, 2*F-1, "R3 OR of limits, alternate flits");
        chk("R5 token wrapped", token_hub, 0);
        one_round(0, E, "R2 epoch after wrap");
        one_round(1, F, "R3 flit limit repeat");
        // R8 encoder sweep
        for (int v = 0; v < 16; v++) begin
            vc_busy = 4'(v);
            #1;
            chk("R8 ctrl word", ctrl_word, word_of(4'(v)));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule